// File: doc/BRIEF.md
# Battery Pack Protection Controller

This block is the decision logic of a multi-cell lithium pack guard. It takes already-digitised condition flags and drives two path controls: one that blocks charging and one that blocks discharging. The flags are: any cell above the overvoltage level, all cells below the charge re-enable level, and any cell below the undervoltage level, all from a cell scanner. Two more bits come from continuous comparators: an overcurrent flag and a charger-present flag. An external pack-off input forces both paths off.

Each fault must persist before it acts. The overvoltage, undervoltage and overcurrent flags each feed a cycle counter with its own terminal-count input, and a counter returns to zero as soon as its flag drops. An overvoltage trip blocks charging until the scanner reports that every cell has fallen below the re-enable level. An undervoltage trip blocks discharge and puts the controller into a low-power sleep state, which is also its state after reset. Only a detected charger wakes it. An overcurrent trip blocks discharge until the overcurrent flag clears. The sleep state is presented to the scanner so that it can slow or stop sampling.

Top module: `pack_guard`

## Requirements
- R1: While reset is held and right after it is released, sleep_o is 1, dsg_off_o is at the active level and chg_off_o is at the inactive level.
- R2: In sleep, a cycle with chg_det_i high ends sleep at that edge: sleep_o becomes 0 and dsg_off_o goes inactive. sleep_o never falls without chg_det_i sampled high.
- R3: With ov_limit_i = L, chg_off_o goes active after the edge at which over_flag_i has been sampled high on L+1 consecutive edges. dsg_off_o is not affected.
- R4: Once tripped by overvoltage, chg_off_o stays active after over_flag_i drops. It returns inactive only after an edge at which ce_flag_i is sampled high.
- R5: With uv_limit_i = L and the controller awake, under_flag_i sampled high on L+1 consecutive edges drives dsg_off_o active and sleep_o to 1. chg_off_o is not affected.
- R6: With oc_limit_i = L and pack_off_i low, ocur_i sampled high on L+1 consecutive edges drives dsg_off_o active without entering sleep. chg_off_o is not affected.
- R7: After an overcurrent trip, dsg_off_o returns inactive at the first edge at which ocur_i is sampled low.
- R8: While pack_off_i is high, both chg_off_o and dsg_off_o are at the active level in the same cycle, without waiting for a clock edge.
- R9: While pack_off_i is high, the overcurrent counter is held at zero. After it falls with ocur_i still high, a full L+1 edges of overcurrent are needed to trip.
- R10: A flag that drops before its count is complete leaves its output unchanged and restarts its counter from zero.
- R11: Parameter OFF_LEVEL sets the active level of both path outputs (default 1: a high output turns the path off). With OFF_LEVEL = 0 both outputs are the bitwise inverse of the default build. sleep_o is 1 in sleep under either setting.
- R12: The undervoltage counter is held at zero during sleep. After waking with under_flag_i still high, another L+1 edges are needed before sleep is re-entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| over_flag_i | input | 1 | Some cell is above the overvoltage level |
| ce_flag_i | input | 1 | Every cell is below the charge re-enable level |
| under_flag_i | input | 1 | Some cell is below the undervoltage level |
| ocur_i | input | 1 | Discharge overcurrent comparator bit |
| chg_det_i | input | 1 | Charger-present comparator bit |
| pack_off_i | input | 1 | External override: turn both paths off |
| ov_limit_i | input | CNT_W | Overvoltage terminal count |
| uv_limit_i | input | CNT_W | Undervoltage terminal count |
| oc_limit_i | input | CNT_W | Overcurrent terminal count |
| chg_off_o | output | 1 | Charge path control (OFF_LEVEL = path off) |
| dsg_off_o | output | 1 | Discharge path control (OFF_LEVEL = path off) |
| sleep_o | output | 1 | Low-power state indication to the scanner |

## Verification
On every cycle the assertions check the causal rules. A path control may only come on after its own flag was sampled. The charge block may only lift after the re-enable flag. Sleep may only end after a charger was seen. The override forces both outputs at once. A fresh fault cannot fire in its first cycle unless its limit is zero. The bench sweeps terminal counts from 0 to 4 against every fault length up to two past the limit, which shows the exact edge at which each trip happens. Its scenarios also cover the hysteresis hold, the counter held through the override and through sleep, and the inverted-polarity build; no single-cycle property can show these.

// File: rtl/pack_guard_pkg.sv
package pack_guard_pkg;

    localparam int NUM_TMR = 3;
    localparam int TMR_OV  = 0;
    localparam int TMR_UV  = 1;
    localparam int TMR_OC  = 2;

    typedef enum logic [0:0] {
        ST_SLEEP = 1'b0,
        ST_RUN   = 1'b1
    } pg_state_e;

    typedef struct packed {
        pg_state_e state;
        logic      chg_block;
        logic      oc_trip;
    } pg_ctrl_s;

endpackage

// File: rtl/guard_timer.sv
module guard_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             fire_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             at_limit;

    assign at_limit = (cnt_q >= limit_i);

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (!at_limit) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign fire_o = run_i && at_limit;

    // R10
    fresh_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!run_i) && run_i && (limit_i != '0)) |-> !fire_o);

endmodule

// File: rtl/guard_core.sv
module guard_core
    import pack_guard_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               over_i,
    input  logic               ce_i,
    input  logic               under_i,
    input  logic               ocur_i,
    input  logic               chg_det_i,
    input  logic               pack_off_i,
    input  logic [NUM_TMR-1:0] fire_i,
    output logic [NUM_TMR-1:0] run_o,
    output logic               chg_raw_o,
    output logic               dsg_raw_o,
    output logic               sleep_o
);

    pg_ctrl_s ctrl_d, ctrl_q;
    logic     asleep;

    assign asleep = (ctrl_q.state == ST_SLEEP);

    // Timer gating: undervoltage only counts while awake, overcurrent is held by override
    always_comb begin
        run_o         = '0;
        run_o[TMR_OV] = over_i;
        run_o[TMR_UV] = under_i && !asleep;
        run_o[TMR_OC] = ocur_i && !pack_off_i;
    end

    always_comb begin
        ctrl_d = ctrl_q;

        if (fire_i[TMR_OV]) begin
            ctrl_d.chg_block = 1'b1;
        end else if (ce_i) begin
            ctrl_d.chg_block = 1'b0;
        end

        if (fire_i[TMR_OC]) begin
            ctrl_d.oc_trip = 1'b1;
        end else if (!ocur_i) begin
            ctrl_d.oc_trip = 1'b0;
        end

        unique case (ctrl_q.state)
            ST_SLEEP: if (chg_det_i)      ctrl_d.state = ST_RUN;
            ST_RUN:   if (fire_i[TMR_UV]) ctrl_d.state = ST_SLEEP;
            default:                      ctrl_d.state = ST_SLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_SLEEP, chg_block: 1'b0, oc_trip: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign chg_raw_o = pack_off_i || ctrl_q.chg_block;
    assign dsg_raw_o = pack_off_i || asleep || ctrl_q.oc_trip;
    assign sleep_o   = asleep;

    // R2
    wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> $past(chg_det_i));

    // R3
    ov_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.chg_block) |-> $past(over_i));

    // R4
    ce_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_q.chg_block) |-> $past(ce_i));

    // R5
    uv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(under_i));

    // R6
    oc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.oc_trip) |-> $past(ocur_i && !pack_off_i));

    // R7
    oc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.oc_trip && !ocur_i) |=> !ctrl_q.oc_trip);

endmodule

// File: rtl/pack_guard.sv
module pack_guard
    import pack_guard_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter bit OFF_LEVEL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             over_flag_i,
    input  logic             ce_flag_i,
    input  logic             under_flag_i,
    input  logic             ocur_i,
    input  logic             chg_det_i,
    input  logic             pack_off_i,
    input  logic [CNT_W-1:0] ov_limit_i,
    input  logic [CNT_W-1:0] uv_limit_i,
    input  logic [CNT_W-1:0] oc_limit_i,
    output logic             chg_off_o,
    output logic             dsg_off_o,
    output logic             sleep_o
);

    logic [NUM_TMR-1:0] tmr_run;
    logic [NUM_TMR-1:0] tmr_fire;
    logic [CNT_W-1:0]   tmr_limit [NUM_TMR];
    logic               chg_raw, dsg_raw;

    assign tmr_limit[TMR_OV] = ov_limit_i;
    assign tmr_limit[TMR_UV] = uv_limit_i;
    assign tmr_limit[TMR_OC] = oc_limit_i;

    for (genvar t = 0; t < NUM_TMR; t++) begin : gen_tmr
        guard_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .run_i   (tmr_run[t]),
            .limit_i (tmr_limit[t]),
            .fire_o  (tmr_fire[t])
        );
    end

    guard_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .over_i     (over_flag_i),
        .ce_i       (ce_flag_i),
        .under_i    (under_flag_i),
        .ocur_i     (ocur_i),
        .chg_det_i  (chg_det_i),
        .pack_off_i (pack_off_i),
        .fire_i     (tmr_fire),
        .run_o      (tmr_run),
        .chg_raw_o  (chg_raw),
        .dsg_raw_o  (dsg_raw),
        .sleep_o    (sleep_o)
    );

    if (OFF_LEVEL) begin : gen_pol_high
        assign chg_off_o = chg_raw;
        assign dsg_off_o = dsg_raw;
    end else begin : gen_pol_low
        assign chg_off_o = ~chg_raw;
        assign dsg_off_o = ~dsg_raw;
    end

    // R8
    override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pack_off_i |-> (chg_off_o == OFF_LEVEL) && (dsg_off_o == OFF_LEVEL));

endmodule

// File: tb/pack_guard_bench.sv
module pack_guard_bench;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          over_f, ce_f, under_f, ocur, chg_det, pack_off;
    logic [CW-1:0] ov_lim, uv_lim, oc_lim;
    logic          chg_off, dsg_off, slp;
    logic          chg_off_n, dsg_off_n, slp_n;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    pack_guard #(.CNT_W(CW), .OFF_LEVEL(1'b1)) u_pack_guard (
        .clk(clk), .rst_n(rst_n), .over_flag_i(over_f), .ce_flag_i(ce_f),
        .under_flag_i(under_f), .ocur_i(ocur), .chg_det_i(chg_det),
        .pack_off_i(pack_off), .ov_limit_i(ov_lim), .uv_limit_i(uv_lim),
        .oc_limit_i(oc_lim), .chg_off_o(chg_off), .dsg_off_o(dsg_off),
        .sleep_o(slp)
    );

    pack_guard #(.CNT_W(CW), .OFF_LEVEL(1'b0)) u_pack_guard_inv (
        .clk(clk), .rst_n(rst_n), .over_flag_i(over_f), .ce_flag_i(ce_f),
        .under_flag_i(under_f), .ocur_i(ocur), .chg_det_i(chg_det),
        .pack_off_i(pack_off), .ov_limit_i(ov_lim), .uv_limit_i(uv_lim),
        .oc_limit_i(oc_lim), .chg_off_o(chg_off_n), .dsg_off_o(dsg_off_n),
        .sleep_o(slp_n)
    );

    task automatic check1(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // expected chg/dsg given as "path off" (1) and checked on both polarity builds
    task automatic expect_out(string req, logic e_chg, logic e_dsg, logic e_slp);
        check1({req, " chg"}, chg_off, e_chg);
        check1({req, " dsg"}, dsg_off, e_dsg);
        check1({req, " sleep"}, slp, e_slp);
        check1("R11 chg inverted", chg_off_n, ~e_chg);
        check1("R11 dsg inverted", dsg_off_n, ~e_dsg);
        check1("R11 sleep", slp_n, e_slp);
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wake();
        chg_det = 1'b1;
        step(1);
        chg_det = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 50000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; over_f = 0; ce_f = 0; under_f = 0; ocur = 0;
        chg_det = 0; pack_off = 0; ov_lim = '0; uv_lim = '0; oc_lim = '0;
        @(negedge clk);
        step(2);
        expect_out("R1 in reset", 1'b0, 1'b1, 1'b1);
        rst_n = 1'b1;
        step(1);
        expect_out("R1 after reset", 1'b0, 1'b1, 1'b1);

        wake();
        expect_out("R2 wake", 1'b0, 1'b0, 1'b0);

        // overvoltage sweep: R3 trip edge, R10 early drop, R4 hysteresis
        for (int lim = 0; lim <= 4; lim++) begin
            ov_lim = CW'(lim);
            for (int n = 1; n <= lim + 2; n++) begin
                logic trip;
                trip = (n >= lim + 1);
                over_f = 1'b1;
                step(n);
                expect_out(trip ? "R3 ov trip" : "R10 ov early", trip, 1'b0, 1'b0);
                over_f = 1'b0;
                step(2);
                expect_out("R4 ov hold", trip, 1'b0, 1'b0);
                if (trip) begin
                    ce_f = 1'b1;
                    step(1);
                    ce_f = 1'b0;
                    expect_out("R4 ce release", 1'b0, 1'b0, 1'b0);
                end
            end
        end

        // overcurrent sweep: R6 trip, R10 early drop, R7 release
        for (int lim = 0; lim <= 4; lim++) begin
            oc_lim = CW'(lim);
            for (int n = 1; n <= lim + 2; n++) begin
                logic trip;
                trip = (n >= lim + 1);
                ocur = 1'b1;
                step(n);
                expect_out(trip ? "R6 oc trip" : "R10 oc early", 1'b0, trip, 1'b0);
                ocur = 1'b0;
                step(1);
                expect_out("R7 oc release", 1'b0, 1'b0, 1'b0);
            end
        end

        // override: R8 immediate, R9 overcurrent counter held
        oc_lim = CW'(2);
        pack_off = 1'b1;
        #1;
        check1("R8 chg forced", chg_off, 1'b1);
        check1("R8 dsg forced", dsg_off, 1'b1);
        @(negedge clk);
        ocur = 1'b1;
        step(10);
        expect_out("R8 override held", 1'b1, 1'b1, 1'b0);
        pack_off = 1'b0;
        #1;
        check1("R9 release no trip", dsg_off, 1'b0);
        @(negedge clk);
        step(1);
        expect_out("R9 count restarted", 1'b0, 1'b0, 1'b0);
        step(1);
        expect_out("R9 full delay trip", 1'b0, 1'b1, 1'b0);
        ocur = 1'b0;
        step(1);
        expect_out("R7 after override", 1'b0, 1'b0, 1'b0);

        // undervoltage sweep: R5 trip, R10 early drop, R12 counter held in sleep
        for (int lim = 0; lim <= 4; lim++) begin
            uv_lim = CW'(lim);
            for (int n = 1; n <= lim + 2; n++) begin
                logic trip;
                trip = (n >= lim + 1);
                under_f = 1'b1;
                step(n);
                expect_out(trip ? "R5 uv trip" : "R10 uv early", 1'b0, trip, trip);
                under_f = 1'b0;
                step(1);
                if (trip) begin
                    under_f = 1'b1;
                    step(lim + 3);
                    expect_out("R12 asleep", 1'b0, 1'b1, 1'b1);
                    wake();
                    expect_out("R2 rewake", 1'b0, 1'b0, 1'b0);
                    step(lim);
                    expect_out("R12 no early sleep", 1'b0, 1'b0, 1'b0);
                    under_f = 1'b0;
                    step(1);
                    expect_out("R12 awake", 1'b0, 1'b0, 1'b0);
                end
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule